// File: doc/BRIEF.md
# Three-Phase Time-Sharing Scanner

This block lets a single power-factor correction controller serve three mains phases in turn. It takes the squared line-voltage waveform as its time base and turns each rising edge into one base tick. A free-running prescaler counts these ticks. A tap select chooses which prescaler bit sets how long each phase is observed. Each time the chosen bit wraps, a three-state phase counter steps to the next phase.

The block drives two one-hot groups of outputs. The first group selects the analog switches that route the active phase's voltage and current to the shared controller. The second group carries the capture strobes. Each strobe is high for the final base-tick interval of its phase's dwell, so the phase's output register takes the controller result only after the controller has watched that phase for the rest of the dwell.

The strobe is formed by decoding the phase that will hold after the next tick and one tick after that. The first decode is ANDed with the inverse of the second, which leaves a strobe only where the phase is about to leave.

Top module: `tri_phase_scanner`

## Requirements
- R1: A rising edge on `mains_sq` is synchronised through two flip-flops and produces exactly one base tick. This holds however long the input stays high.
- R2: With `tap_sel` = t held constant since reset, each phase is active for exactly 2^(t+1) base ticks. After n ticks the active phase is floor(n / 2^(t+1)) mod 3.
- R3: The phases step in the order 0, 1, 2, 0, and so on. `route_sel` is one-hot, with bit p high while phase p is active. The phase code never holds a fourth value, and any illegal code returns to phase 0 on the next clock.
- R4: `latch_stb` bit p is high during the last base-tick interval of phase p's dwell, and only while `route_sel` bit p is high. After n ticks the strobe is set exactly when n mod 2^(t+1) equals 2^(t+1)-1.
- R5: At most one strobe bit is high at a time. A strobe lasts one base-tick interval and is cleared by the tick that ends the dwell.
- R6: The phase advances on a tick at which prescaler bits [t:0] are all ones. A change of `tap_sel` never clears the prescaler and takes effect at the next tick.
- R7: With `rst_n` low at a clock edge, the prescaler and phase counter clear, `route_sel` becomes 3'b001 and `latch_stb` becomes 3'b000.
- R8: `route_sel` and `latch_stb` change only on a clock at which a base tick is present. They are stable between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mains_sq | input | 1 | Squared line-voltage waveform, asynchronous to clk |
| tap_sel | input | 4 | Prescaler bit that sets the dwell per phase (0 to 15) |
| route_sel | output | 3 | One-hot analog switch select, bit p for phase p |
| latch_stb | output | 3 | Capture strobe for each phase's output register |

## Verification
A prescaler that skips or repeats a count moves every later phase boundary. This shows at `route_sel` within one dwell of the error, and the closed-form sweep catches it at the first tick that disagrees. A phase code that skips or reorders states gives a wrong or rotated `route_sel` right after the next advance. A strobe decoded from the wrong lookahead appears one tick early or late, or on the wrong bit. This is seen at the first dwell end of the same sweep. Synchroniser faults, such as a missing edge detect, give extra ticks while the input is held high, and the held-level test exposes them within one mains cycle.

// File: rtl/scan_pkg.sv
// Package for the three-phase scanner: phase code type and helpers.
// Assumes exactly three phases; code 2'd3 is illegal.
package scan_pkg;
    typedef logic [1:0] phase_t;

    localparam phase_t PH_FIRST = 2'd0;
    localparam phase_t PH_LAST  = 2'd2;

    // Next phase in scan order; any illegal code maps to the first phase.
    function automatic phase_t phase_step(input phase_t cur);
        if (cur < PH_LAST) return cur + 2'd1;
        return PH_FIRST;
    endfunction

    // One-hot decode of a phase code (illegal code decodes to zero).
    function automatic logic [2:0] phase_decode(input phase_t cur);
        logic [2:0] d;
        d = 3'b000;
        for (int i = 0; i < 3; i++) d[i] = (cur == phase_t'(i));
        return d;
    endfunction
endpackage

// File: rtl/mains_edge_sync.sv
// Synchronises the squared mains waveform into the clk domain and emits a
// one-clock tick per rising edge. Assumes the input stays high and low for
// at least two clk periods each.
module mains_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sq_in,
    output logic tick_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the asynchronous level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sq_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign tick_o = sync_q[SYNC_STAGES-1] & ~prev_q;

    // R1: a tick is never wider than one clock.
    assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/dwell_prescaler.sv
// Free-running tick counter with a selectable tap. Signals an advance when
// bits [tap:0] are all ones at a tick, and whether the count after this
// tick will sit in the last slot of a dwell. The tap may change at any time.
module dwell_prescaler #(
    parameter int PRE_W = 16,
    parameter int TAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic             adv_o,
    output logic             last_next_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_inc;
    logic [PRE_W-1:0] mask;

    // Build the mask of bits at or below the chosen tap.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) mask[i] = (i <= int'(tap_i));
    end

    assign pre_inc     = pre_q + 1'b1;
    assign adv_o       = tick_i & (&(pre_q | ~mask));
    assign last_next_o = &(pre_inc | ~mask);

    // Count base ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (tick_i) pre_q <= pre_inc;
    end

    // R6: the counter moves only on ticks, by exactly one.
    assert_pre_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(tick_i) |-> $stable(pre_q));
endmodule

// File: rtl/phase_ring.sv
// Three-state phase counter with a one-hot shift-register copy that drives
// the analog switches. Exposes the phase after the next tick and the phase
// one tick beyond that, for strobe shaping. Illegal states recover to phase 0.
module phase_ring
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       adv_i,
    input  logic       last_next_i,
    output phase_t     nxt_o,
    output phase_t     look_o,
    output logic [2:0] sel_o
);
    phase_t     code_q;
    logic [2:0] sel_q;

    assign nxt_o  = (code_q > PH_LAST) ? PH_FIRST :
                    (adv_i ? phase_step(code_q) : code_q);
    assign look_o = last_next_i ? phase_step(nxt_o) : nxt_o;

    // Hold the binary phase code; illegal codes fall back to phase 0.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= PH_FIRST;
        else        code_q <= nxt_o;
    end

    // Rotate the one-hot select register with each advance.
    always_ff @(posedge clk) begin
        if (!rst_n || ($countones(sel_q) != 1)) sel_q <= 3'b001;
        else if (adv_i)                         sel_q <= {sel_q[1:0], sel_q[2]};
    end

    assign sel_o = sel_q;

    // R3: the code never reaches a fourth state.
    assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        code_q <= PH_LAST);
    // R3: the shift register agrees with the decoded binary code.
    assert_sel_tracks_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q == phase_decode(code_q));
    // R3: any change of select is a single rotation in scan order.
    assert_scan_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (sel_q != $past(sel_q)) |-> sel_q == {$past(sel_q[1:0]), $past(sel_q[2])});
    // R8: the select moves only after a tick.
    assert_sel_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(sel_q));
endmodule

// File: rtl/strobe_shaper.sv
// Forms the per-phase capture strobes: the decoded phase after this tick is
// ANDed with the inverse of the decoded phase one tick later, so a strobe
// appears only in the last tick interval of a dwell. Updates on ticks only.
module strobe_shaper
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  phase_t     nxt_i,
    input  phase_t     look_i,
    input  logic [2:0] sel_i,
    output logic [2:0] stb_o
);
    logic [2:0] stb_q;

    // Register the shaped strobe at each base tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      stb_q <= 3'b000;
        else if (tick_i) stb_q <= phase_decode(nxt_i) & ~phase_decode(look_i);
    end

    assign stb_o = stb_q;

    // R5: never more than one strobe.
    assert_stb_onehot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb_q));
    // R4: a strobe only belongs to the phase being routed.
    assert_stb_matches_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q != 3'b000) |-> (stb_q == sel_i));
    // R5: the tick that ends the dwell clears the strobe.
    assert_stb_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q != 3'b000) && tick_i |=> (stb_q == 3'b000));
    // R8: strobes hold between ticks.
    assert_stb_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(stb_q));
endmodule

// File: rtl/tri_phase_scanner.sv
// Top of the three-phase time-sharing scanner. Turns the squared mains
// waveform into base ticks, divides them by a selectable prescaler tap and
// steps one shared controller across three phases, driving switch selects
// and per-phase capture strobes. Assumes one mains edge per cycle.
module tri_phase_scanner
    import scan_pkg::*;
#(
    parameter int PRE_W = 16,
    parameter int TAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mains_sq,
    input  logic [TAP_W-1:0] tap_sel,
    output logic [2:0]       route_sel,
    output logic [2:0]       latch_stb
);
    logic   tick;
    logic   adv;
    logic   last_next;
    phase_t ph_nxt;
    phase_t ph_look;

    mains_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sq_in  (mains_sq),
        .tick_o (tick)
    );

    dwell_prescaler #(.PRE_W(PRE_W), .TAP_W(TAP_W)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .tap_i       (tap_sel),
        .adv_o       (adv),
        .last_next_o (last_next)
    );

    phase_ring u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .adv_i       (adv),
        .last_next_i (last_next),
        .nxt_o       (ph_nxt),
        .look_o      (ph_look),
        .sel_o       (route_sel)
    );

    strobe_shaper u_stb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .nxt_i  (ph_nxt),
        .look_i (ph_look),
        .sel_i  (route_sel),
        .stb_o  (latch_stb)
    );
endmodule

// File: tb/sim_tri_phase_scanner.sv
module sim_tri_phase_scanner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mains_sq = 1'b0;
    logic [3:0] tap_sel = 4'd0;
    logic [2:0] route_sel;
    logic [2:0] latch_stb;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    tri_phase_scanner u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mains_sq  (mains_sq),
        .tap_sel   (tap_sel),
        .route_sel (route_sel),
        .latch_stb (latch_stb)
    );

    task automatic chk(input string req, input string what, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0; mains_sq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One mains cycle: 2 clocks high, 2 low; outputs settled at the end.
    task automatic mains_cycle();
        @(negedge clk) mains_sq = 1'b1;
        repeat (2) @(negedge clk);
        mains_sq = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [2:0] hot(input int p);
        return 3'b001 << p;
    endfunction

    initial begin
        // R7: reset state
        do_reset();
        chk("R7", "route after reset", route_sel, 3'b001);
        chk("R7", "strobe after reset", latch_stb, 3'b000);

        // R2, R3, R4, R5: closed-form sweep over small taps
        for (int t = 0; t <= 4; t++) begin
            int period;
            period = 2 << t;
            tap_sel = 4'(t);
            do_reset();
            for (int n = 1; n <= 6 * period + 3; n++) begin
                mains_cycle();
                chk("R2_R3", $sformatf("route tap %0d tick %0d", t, n), route_sel, hot((n / period) % 3));
                chk("R4_R5", $sformatf("strobe tap %0d tick %0d", t, n), latch_stb,
                    ((n % period) == period - 1) ? hot((n / period) % 3) : 3'b000);
            end
        end

        // R2: widest tap stays on phase 0 for a long run
        tap_sel = 4'd15;
        do_reset();
        for (int n = 1; n <= 200; n++) begin
            mains_cycle();
            if (n % 50 == 0) begin
                chk("R2", "route tap 15", route_sel, 3'b001);
                chk("R4", "strobe tap 15", latch_stb, 3'b000);
            end
        end

        // R1: held-high input gives one tick only (tap 0: one tick -> strobe on phase 0)
        tap_sel = 4'd0;
        do_reset();
        @(negedge clk) mains_sq = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1", "route after held high", route_sel, 3'b001);
        chk("R1", "strobe after held high", latch_stb, 3'b001);
        mains_sq = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "no tick on fall", latch_stb, 3'b001);

        // R8: outputs stable between ticks
        mains_cycle();
        chk("R8", "route after 2nd tick", route_sel, 3'b010);
        repeat (10) @(negedge clk);
        chk("R8", "route stable without tick", route_sel, 3'b010);
        chk("R8", "strobe stable without tick", latch_stb, 3'b000);

        // R6: tap change mid-dwell, prescaler not cleared
        tap_sel = 4'd2;
        do_reset();
        repeat (3) mains_cycle();
        chk("R6", "route before tap change", route_sel, 3'b001);
        tap_sel = 4'd0;
        mains_cycle();
        chk("R6", "route after tap change", route_sel, 3'b010);
        chk("R6", "strobe after tap change", latch_stb, 3'b000);
        mains_cycle();
        chk("R6", "strobe second tick", latch_stb, 3'b010);
        mains_cycle();
        chk("R6", "route third tick", route_sel, 3'b100);

        // R7: reset mid-run
        do_reset();
        chk("R7", "route after mid-run reset", route_sel, 3'b001);
        chk("R7", "strobe after mid-run reset", latch_stb, 3'b000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule